// File: doc/BRIEF.md
# Lockstep Core Output Comparator

This block sits beside a set of redundant processor cores that execute the same program in lockstep. Every clock cycle it looks at the output bus of each core and decides, for each of a parameterised number of port groups, whether all cores agree on that group. Caches and other shared resources are outside the comparison: only the core outputs enter it.

When the first disagreement appears, the block stores a per-group divergence signature. The signature records which output groups differed, and it is kept unchanged so that a diagnosis handler can later work out which part of a core most likely failed. At the same time the block holds every core with a stall line and raises a level error interrupt. Software reads the signature and then pulses a clear input, which releases the cores and re-arms the comparator. Adding cores widens only the comparison logic. The signature keeps the same width, one bit per group.

The controller is a two-state machine. `ST_RUN` compares and waits. The transition `T_DETECT` (any group divergent while in `ST_RUN`) loads the signature and enters `ST_HALT`. `ST_HALT` drives stall and interrupt and ignores the inputs. The transition `T_CLEAR` (clear pulse while in `ST_HALT`) wipes the signature and returns to `ST_RUN`.

Top module: `lockstep_cmp`

## Requirements
- R1: After reset, `stall_o`, `err_irq_o` and every bit of `div_vec_o` are 0, and the controller is in `ST_RUN`.
- R2: Core c drives bits `[c*BUS_W +: BUS_W]` of `core_out_i`. Group g is bits `[g*GRP_W +: GRP_W]` of each core bus. The combinational `mismatch_o` is 1 in a cycle exactly when some group differs in at least one bit between some pair of cores.
- R3: With three or more cores, a group counts as divergent whenever the cores do not all agree on it, even when a majority of them agree.
- R4: On the first clock edge that samples a mismatch in `ST_RUN`, `div_vec_o` bit g loads 1 exactly for each divergent group g. From that edge on, `stall_o` and `err_irq_o` are 1.
- R5: While in `ST_HALT`, `div_vec_o` keeps its captured value whatever the core outputs do.
- R6: `stall_o` and the level interrupt `err_irq_o` stay at 1 for as long as the capture is pending, until a clear pulse.
- R7: A clear pulse in `ST_HALT` returns the block to `ST_RUN` at the next edge, with `stall_o`, `err_irq_o` and `div_vec_o` all 0.
- R8: A clear pulse in `ST_RUN` has no effect: outputs stay 0 and a later mismatch is still captured.
- R9: While all cores agree, `stall_o` and `err_irq_o` remain 0.
- R10: When several groups diverge in the same cycle, possibly from different cores, all of their bits are set together in the signature.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| core_out_i | input | NUM_CORES*GROUPS*GRP_W | Concatenated output buses of all cores, core 0 in the low bits |
| clear_i | input | 1 | Software clear pulse that releases a pending capture |
| mismatch_o | output | 1 | Live, unregistered disagreement flag for the current cycle |
| stall_o | output | 1 | Stall to all lockstepped cores |
| err_irq_o | output | 1 | Level error interrupt while a capture is pending |
| div_vec_o | output | GROUPS | Frozen per-group divergence signature |

## Verification
On every cycle the assertions check the controller's promises: a mismatch seen while running leads to stall with a non-empty signature, the signature stays fixed during a halt without clear, and stall persists until clear. They also check that a clear wipes everything, that agreeing cores never cause a stall, and that the signature is empty while running. Only the bench's scenarios can show that the bits land on the correct group for a given core and bit position, that a single dissenting core out of three is caught, and that several groups from different cores are recorded together.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
    typedef enum logic [0:0] {
        ST_RUN  = 1'b0,
        ST_HALT = 1'b1
    } lsc_state_e;
endpackage

// File: rtl/lsc_group_cmp.sv
// Decides whether all cores agree on one port group.
module lsc_group_cmp #(
    parameter int NUM_CORES = 3,
    parameter int GRP_W     = 8
) (
    input  logic [NUM_CORES*GRP_W-1:0] slices_i,
    output logic                       diverge_o
);
    logic [NUM_CORES-1:0] differs;

    assign differs[0] = 1'b0;

    // All cores agree iff each one equals core 0.
    for (genvar c = 1; c < NUM_CORES; c++) begin : g_core
        assign differs[c] = (slices_i[c*GRP_W +: GRP_W] != slices_i[0 +: GRP_W]);
    end

    assign diverge_o = |differs;
endmodule

// File: rtl/lsc_ctrl.sv
// Two-state controller: run/compare and halted with a pending capture.
module lsc_ctrl
    import lsc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mismatch_i,
    input  logic       clear_i,
    output lsc_state_e state_o,
    output logic       capture_o,
    output logic       wipe_o,
    output logic       stall_o,
    output logic       irq_o
);
    lsc_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (mismatch_i) state_d = ST_HALT; // T_DETECT
            ST_HALT: if (clear_i)    state_d = ST_RUN;  // T_CLEAR
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        capture_o = 1'b0;
        wipe_o    = 1'b0;
        stall_o   = 1'b0;
        irq_o     = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                capture_o = mismatch_i;
            end
            ST_HALT: begin
                stall_o = 1'b1;
                irq_o   = 1'b1;
                wipe_o  = clear_i;
            end
            default: ;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/lsc_capture.sv
// Holds the per-group divergence signature.
module lsc_capture #(
    parameter int GROUPS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_i,
    input  logic              wipe_i,
    input  logic [GROUPS-1:0] live_i,
    output logic [GROUPS-1:0] sig_o
);
    logic [GROUPS-1:0] sig_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         sig_q <= '0;
        else if (capture_i) sig_q <= live_i;
        else if (wipe_i)    sig_q <= '0;
    end

    assign sig_o = sig_q;
endmodule

// File: rtl/lockstep_cmp.sv
module lockstep_cmp
    import lsc_pkg::*;
#(
    parameter int NUM_CORES = 3,
    parameter int GROUPS    = 4,
    parameter int GRP_W     = 8,
    localparam int BUS_W    = GROUPS * GRP_W,
    localparam int ALL_W    = NUM_CORES * BUS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ALL_W-1:0]  core_out_i,
    input  logic              clear_i,
    output logic              mismatch_o,
    output logic              stall_o,
    output logic              err_irq_o,
    output logic [GROUPS-1:0] div_vec_o
);
    logic [NUM_CORES*GRP_W-1:0] grp_slice [GROUPS];
    logic [GROUPS-1:0]          live_div;
    logic                       capture_en;
    logic                       wipe_en;
    lsc_state_e                 state;

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        for (genvar c = 0; c < NUM_CORES; c++) begin : g_gather
            assign grp_slice[g][c*GRP_W +: GRP_W] = core_out_i[c*BUS_W + g*GRP_W +: GRP_W];
        end
        lsc_group_cmp #(
            .NUM_CORES (NUM_CORES),
            .GRP_W     (GRP_W)
        ) u_cmp (
            .slices_i  (grp_slice[g]),
            .diverge_o (live_div[g])
        );
    end

    assign mismatch_o = |live_div;

    lsc_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .mismatch_i (mismatch_o),
        .clear_i    (clear_i),
        .state_o    (state),
        .capture_o  (capture_en),
        .wipe_o     (wipe_en),
        .stall_o    (stall_o),
        .irq_o      (err_irq_o)
    );

    lsc_capture #(
        .GROUPS (GROUPS)
    ) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (capture_en),
        .wipe_i    (wipe_en),
        .live_i    (live_div),
        .sig_o     (div_vec_o)
    );
endmodule

// File: rtl/lockstep_cmp_chk.sv
module lockstep_cmp_chk #(
    parameter int GROUPS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clear_i,
    input logic              mismatch_o,
    input logic              stall_o,
    input logic              err_irq_o,
    input logic [GROUPS-1:0] div_vec_o
);
    AST_DETECT_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_o && mismatch_o) |=> (stall_o && err_irq_o && div_vec_o != '0)); // R4

    AST_SIG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_o && !clear_i) |=> $stable(div_vec_o)); // R5

    AST_STALL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_o && !clear_i) |=> (stall_o && err_irq_o)); // R6

    AST_CLEAR_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_o && clear_i) |=> (!stall_o && !err_irq_o && div_vec_o == '0)); // R7

    AST_AGREE_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall_o && !mismatch_o) |=> !stall_o); // R9

    AST_RUN_SIG_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !stall_o |-> (div_vec_o == '0)); // R8
endmodule

bind lockstep_cmp lockstep_cmp_chk #(
    .GROUPS (GROUPS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (clear_i),
    .mismatch_o (mismatch_o),
    .stall_o    (stall_o),
    .err_irq_o  (err_irq_o),
    .div_vec_o  (div_vec_o)
);

// File: tb/lockstep_cmp_bench.sv
module lockstep_cmp_bench;
    localparam int NUM_CORES = 3;
    localparam int GROUPS    = 4;
    localparam int GRP_W     = 8;
    localparam int BUS_W     = GROUPS * GRP_W;
    localparam int ALL_W     = NUM_CORES * BUS_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ALL_W-1:0]  core_out = '0;
    logic              clear = 1'b0;
    logic              mismatch, stall, irq;
    logic [GROUPS-1:0] div_vec;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    lockstep_cmp #(
        .NUM_CORES (NUM_CORES),
        .GROUPS    (GROUPS),
        .GRP_W     (GRP_W)
    ) u_lockstep_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .core_out_i (core_out),
        .clear_i    (clear),
        .mismatch_o (mismatch),
        .stall_o    (stall),
        .err_irq_o  (irq),
        .div_vec_o  (div_vec)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic all_same(input logic [BUS_W-1:0] v);
        for (int c = 0; c < NUM_CORES; c++) core_out[c*BUS_W +: BUS_W] = v;
    endtask

    task automatic put(input int c, input logic [BUS_W-1:0] v);
        core_out[c*BUS_W +: BUS_W] = v;
    endtask

    // Inputs change at negedge; registered outputs are read at the next negedge.
    task automatic next_cycle();
        @(negedge clk);
    endtask

    task automatic check_outs(input string req, input logic s, input logic [GROUPS-1:0] v);
        check({req, " stall"}, {31'd0, stall}, {31'd0, s});
        check({req, " irq"}, {31'd0, irq}, {31'd0, s});
        check({req, " sig"}, {28'd0, div_vec}, {28'd0, v});
    endtask

    task automatic do_clear();
        clear = 1'b1;
        next_cycle();
        clear = 1'b0;
    endtask

    task automatic t_reset();
        check_outs("R1 reset", 1'b0, 4'b0000);
    endtask

    task automatic t_agree();
        all_same(32'hDEAD_BEEF); #1;
        check("R9 live agree", {31'd0, mismatch}, 32'd0);
        next_cycle();
        all_same(32'h0123_4567);
        next_cycle();
        all_same(32'hFFFF_FFFF);
        next_cycle();
        check_outs("R9 agree", 1'b0, 4'b0000);
    endtask

    task automatic t_single_group();
        all_same(32'h1111_1111);
        put(1, 32'h1115_1111); #1; // bit 18 -> group 2
        check("R2 live", {31'd0, mismatch}, 32'd1);
        next_cycle();
        check_outs("R4 capture", 1'b1, 4'b0100);
    endtask

    task automatic t_freeze();
        all_same(32'h2222_2222);
        put(0, 32'h2222_2223);
        next_cycle();
        check_outs("R5 frozen", 1'b1, 4'b0100);
        all_same(32'h2222_2222);
        next_cycle(); next_cycle();
        check_outs("R6 held", 1'b1, 4'b0100);
    endtask

    task automatic t_clear();
        all_same(32'h3333_3333);
        do_clear();
        check_outs("R7 clear", 1'b0, 4'b0000);
    endtask

    task automatic t_minority();
        all_same(32'h4444_4444);
        put(2, 32'hC444_4444); // group 3, two of three agree
        next_cycle();
        check_outs("R3 minority", 1'b1, 4'b1000);
        all_same(32'h4444_4444);
        do_clear();
    endtask

    task automatic t_multi();
        all_same(32'h5555_5555);
        put(0, 32'h5555_5554); // group 0
        put(1, 32'h5555_5455); // group 1
        next_cycle();
        check_outs("R10 multi", 1'b1, 4'b0011);
        all_same(32'h5555_5555);
        do_clear();
        check_outs("R10 after clear", 1'b0, 4'b0000);
    endtask

    task automatic t_clear_run();
        all_same(32'h6666_6666);
        do_clear();
        check_outs("R8 clear idle", 1'b0, 4'b0000);
        put(1, 32'h6666_E666); // group 1
        next_cycle();
        check_outs("R8 capture after", 1'b1, 4'b0010);
        all_same(32'h6666_6666);
        do_clear();
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        next_cycle();
        t_reset();
        t_agree();
        t_single_group();
        t_freeze();
        t_clear();
        t_minority();
        t_multi();
        t_clear_run();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule